// File: doc/BRIEF.md
# SD Block-Size Segmenting Buffer

This block sits between a DMA segment mover and the data port of an SD card. The DMA side hands it memory segments of any byte length. The card side always moves whole card blocks. A fill counter survives from one segment to the next, so a single card block may be spread over several memory segments.

In the read direction, the block pulls a complete block from the card whenever a chunk starts with an empty buffer. It then hands the bytes to memory in pieces. In the write direction, it collects memory bytes until the buffer holds a full block, then streams that block to the card. An optional block counter can end a segment early once the programmed number of blocks has moved. A segment reports how many memory-side bytes it actually consumed, so the descriptor walker can spot leftover length. An abort input drops any partial block.

Top module: `sd_blkseg`

## Requirements
- R1: The block size is taken from bits 11:0 of `cfg_blk_size`, and bits 15:12 have no effect. A field value of 0, or a value above the buffer depth 2^BUF_AW, is treated as the buffer depth.
- R2: In read mode (`cfg_rd`=1), exactly one block-size run of bytes is accepted on `card_in` at the start of a chunk, and only when the fill count is zero and bytes remain. Buffered bytes reach `mem_out` in the order the card supplied them.
- R3: Each chunk moves, starting at the current fill offset, the smaller of the bytes left in the segment and the bytes needed to finish the block. While `mem_out` is stalled, its valid and data stay stable.
- R4: In write mode (`cfg_rd`=0), `mem_in` bytes are appended to the buffer. When the fill count reaches the block size, the whole block goes out on `card_out` in order and the fill count returns to zero. While `card_out` is stalled, its valid and data stay stable.
- R5: When `cfg_cnt_en` is set at segment start, each completed block decrements `blk_count` by one. A block that completes with the count at 1 ends the segment. A count of 0 at the start of a chunk also ends the segment.
- R6: The fill count is kept between segments. A partial block left by one segment is finished by the next, with no extra card transfer.
- R7: `seg_len` is 17 bits wide and covers 0 to 65536. `seg_done` is a one-cycle pulse, and at that pulse `seg_used` holds the number of memory-side bytes moved. A length of 0 completes with 0 bytes used.
- R8: `abort` returns the block to idle on the next cycle without a done pulse and clears the fill count. The next read fetches a fresh block, and the next write starts a new block.
- R9: At most one of `card_in_ready`, `mem_out_valid`, `mem_in_ready` and `card_out_valid` is high at a time. Only the ones belonging to the latched direction ever rise, and none of them rises while idle.
- R10: `cnt_load` loads `cnt_load_val` into `blk_count`. Without a load, the count does not change while idle or while counting is disabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_blk_size | input | 16 | Block-size register; low 12 bits used |
| cfg_rd | input | 1 | 1: card to memory, 0: memory to card (latched at start) |
| cfg_cnt_en | input | 1 | Enable block counting (latched at start) |
| cnt_load | input | 1 | Load the block counter |
| cnt_load_val | input | 16 | Value loaded into the block counter |
| blk_count | output | 16 | Current block count |
| abort | input | 1 | Drop the segment and any partial block |
| seg_start | input | 1 | Start a segment (accepted when idle) |
| seg_len | input | 17 | Segment length in bytes |
| seg_busy | output | 1 | Segment in progress |
| seg_done | output | 1 | One-cycle completion pulse |
| seg_used | output | 17 | Memory-side bytes consumed by the segment |
| mem_out_valid | output | 1 | Byte toward memory valid |
| mem_out_ready | input | 1 | Memory accepts the byte |
| mem_out_data | output | 8 | Byte toward memory |
| mem_in_valid | input | 1 | Byte from memory valid |
| mem_in_ready | output | 1 | Buffer accepts a memory byte |
| mem_in_data | input | 8 | Byte from memory |
| card_in_valid | input | 1 | Byte from card valid |
| card_in_ready | output | 1 | Buffer accepts a card byte |
| card_in_data | input | 8 | Byte from card |
| card_out_valid | output | 1 | Byte toward card valid |
| card_out_ready | input | 1 | Card accepts the byte |
| card_out_data | output | 8 | Byte toward card |

## Verification
The bench builds the block with BUF_AW=4, which gives a 16-byte buffer, and keeps the other parameters at their defaults. With a buffer that small, a zero field and an oversized field both clamp to the depth. Segments of one, two and three blocks, and blocks split across segments, also finish in a few dozen cycles. A 65536-byte segment stays cheap because the block counter cuts it short after three blocks. Stalls on every stream exercise the hold rules.

// File: rtl/sd_blkseg_pkg.sv
package sd_blkseg_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_CHUNK, ST_FETCH, ST_DRAIN, ST_GATHER, ST_FLUSH, ST_DONE
  } seg_state_e;
endpackage

// File: rtl/sd_blkseg_buf.sv
module sd_blkseg_buf #(
  parameter int AW = 9,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/sd_blkseg_cnt.sv
module sd_blkseg_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             dec,
  output logic [CNT_W-1:0] cnt
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = ld | dec;
    cnt_d  = cnt_q;
    if (ld)       cnt_d = ld_val;
    else if (dec) cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/sd_blkseg_ctl.sv
module sd_blkseg_ctl
  import sd_blkseg_pkg::*;
#(
  parameter int AW    = 9,
  parameter int DW    = 8,
  parameter int LEN_W = 17,
  parameter int CNT_W = 16,
  parameter int BSZ_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [BSZ_W-1:0] bs_field,
  input  logic             cfg_rd,
  input  logic             cfg_cnt_en,
  input  logic             abort,
  input  logic             seg_start,
  input  logic [LEN_W-1:0] seg_len,
  output logic             seg_busy,
  output logic             seg_done,
  output logic [LEN_W-1:0] seg_used,
  input  logic [CNT_W-1:0] cnt_val,
  output logic             blk_dec,
  output logic             buf_we,
  output logic [AW-1:0]    buf_waddr,
  output logic [DW-1:0]    buf_wdata,
  output logic [AW-1:0]    buf_raddr,
  input  logic [DW-1:0]    buf_rdata,
  output logic             mem_out_valid,
  input  logic             mem_out_ready,
  output logic [DW-1:0]    mem_out_data,
  input  logic             mem_in_valid,
  output logic             mem_in_ready,
  input  logic [DW-1:0]    mem_in_data,
  input  logic             card_in_valid,
  output logic             card_in_ready,
  input  logic [DW-1:0]    card_in_data,
  output logic             card_out_valid,
  input  logic             card_out_ready,
  output logic [DW-1:0]    card_out_data
);
  localparam int DEPTH  = 1 << AW;
  localparam int FILL_W = AW + 1;

  seg_state_e       st_q, st_d;
  logic [FILL_W-1:0] fill_q, fill_d, idx_q, idx_d, bs, bs_m1;
  logic [LEN_W-1:0]  rem_q, rem_d, used_q, used_d;
  logic              rd_q, rd_d, cen_q, cen_d;
  logic              fill_end, idx_end, rem_last, cnt_last, cnt_empty;
  logic              fetch_hs, drain_hs, gather_hs, flush_hs;

  // effective block size: zero or oversized field clamps to the buffer depth
  always_comb begin
    if (bs_field == '0 || 32'(bs_field) > DEPTH) bs = FILL_W'(DEPTH);
    else                                         bs = FILL_W'(bs_field);
    bs_m1 = bs - FILL_W'(1);
  end

  assign fill_end  = (fill_q == bs_m1);
  assign idx_end   = (idx_q == bs_m1);
  assign rem_last  = (rem_q == LEN_W'(1));
  assign cnt_last  = cen_q && (cnt_val == CNT_W'(1));
  assign cnt_empty = cen_q && (cnt_val == '0);

  assign card_in_ready  = (st_q == ST_FETCH);
  assign mem_out_valid  = (st_q == ST_DRAIN);
  assign mem_in_ready   = (st_q == ST_GATHER);
  assign card_out_valid = (st_q == ST_FLUSH);

  assign fetch_hs  = card_in_ready & card_in_valid;
  assign drain_hs  = mem_out_valid & mem_out_ready;
  assign gather_hs = mem_in_ready & mem_in_valid;
  assign flush_hs  = card_out_valid & card_out_ready;

  assign buf_we    = fetch_hs | gather_hs;
  assign buf_waddr = card_in_ready ? idx_q[AW-1:0] : fill_q[AW-1:0];
  assign buf_wdata = card_in_ready ? card_in_data : mem_in_data;
  assign buf_raddr = card_out_valid ? idx_q[AW-1:0] : fill_q[AW-1:0];
  assign mem_out_data  = buf_rdata;
  assign card_out_data = buf_rdata;

  assign blk_dec  = cen_q && ((drain_hs && fill_end) || (flush_hs && idx_end));
  assign seg_busy = (st_q != ST_IDLE);
  assign seg_done = (st_q == ST_DONE);
  assign seg_used = used_q;

  always_comb begin
    st_d   = st_q;
    fill_d = fill_q;
    idx_d  = idx_q;
    rem_d  = rem_q;
    used_d = used_q;
    rd_d   = rd_q;
    cen_d  = cen_q;
    unique case (st_q)
      ST_IDLE: if (seg_start) begin
        rem_d  = seg_len;
        used_d = '0;
        rd_d   = cfg_rd;
        cen_d  = cfg_cnt_en;
        st_d   = ST_CHUNK;
      end
      ST_CHUNK: begin
        idx_d = '0;
        if (rem_q == '0 || cnt_empty) st_d = ST_DONE;
        else if (rd_q)                st_d = (fill_q == '0) ? ST_FETCH : ST_DRAIN;
        else                          st_d = ST_GATHER;
      end
      ST_FETCH: if (fetch_hs) begin
        if (idx_end) begin
          idx_d = '0;
          st_d  = ST_DRAIN;
        end else begin
          idx_d = idx_q + FILL_W'(1);
        end
      end
      ST_DRAIN: if (drain_hs) begin
        rem_d  = rem_q - LEN_W'(1);
        used_d = used_q + LEN_W'(1);
        if (fill_end) begin
          fill_d = '0;
          st_d   = cnt_last ? ST_DONE : ST_CHUNK;
        end else begin
          fill_d = fill_q + FILL_W'(1);
          if (rem_last) st_d = ST_DONE;
        end
      end
      ST_GATHER: if (gather_hs) begin
        rem_d  = rem_q - LEN_W'(1);
        used_d = used_q + LEN_W'(1);
        fill_d = fill_q + FILL_W'(1);
        if (fill_end) begin
          idx_d = '0;
          st_d  = ST_FLUSH;
        end else if (rem_last) begin
          st_d = ST_DONE;
        end
      end
      ST_FLUSH: if (flush_hs) begin
        if (idx_end) begin
          idx_d  = '0;
          fill_d = '0;
          st_d   = cnt_last ? ST_DONE : ST_CHUNK;
        end else begin
          idx_d = idx_q + FILL_W'(1);
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
    if (abort) begin
      st_d   = ST_IDLE;
      fill_d = '0;
      idx_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      fill_q <= '0;
      idx_q  <= '0;
      rem_q  <= '0;
      used_q <= '0;
      rd_q   <= 1'b0;
      cen_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      fill_q <= fill_d;
      idx_q  <= idx_d;
      rem_q  <= rem_d;
      used_q <= used_d;
      rd_q   <= rd_d;
      cen_q  <= cen_d;
    end
  end
endmodule

// File: rtl/sd_blkseg.sv
module sd_blkseg #(
  parameter int BUF_AW = 9,
  parameter int DW     = 8,
  parameter int LEN_W  = 17,
  parameter int CNT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [15:0]      cfg_blk_size,
  input  logic             cfg_rd,
  input  logic             cfg_cnt_en,
  input  logic             cnt_load,
  input  logic [CNT_W-1:0] cnt_load_val,
  output logic [CNT_W-1:0] blk_count,
  input  logic             abort,
  input  logic             seg_start,
  input  logic [LEN_W-1:0] seg_len,
  output logic             seg_busy,
  output logic             seg_done,
  output logic [LEN_W-1:0] seg_used,
  output logic             mem_out_valid,
  input  logic             mem_out_ready,
  output logic [DW-1:0]    mem_out_data,
  input  logic             mem_in_valid,
  output logic             mem_in_ready,
  input  logic [DW-1:0]    mem_in_data,
  input  logic             card_in_valid,
  output logic             card_in_ready,
  input  logic [DW-1:0]    card_in_data,
  output logic             card_out_valid,
  input  logic             card_out_ready,
  output logic [DW-1:0]    card_out_data
);
  localparam int BSZ_W = 12;

  logic          rst_s1_q, rst_s2_q, rst_int_n;
  logic          blk_dec, buf_we;
  logic [BUF_AW-1:0] buf_waddr, buf_raddr;
  logic [DW-1:0] buf_wdata, buf_rdata;
  logic          unused_bs_hi;

  assign unused_bs_hi = ^cfg_blk_size[15:BSZ_W];

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_int_n = rst_s2_q;

  sd_blkseg_buf #(.AW(BUF_AW), .DW(DW)) u_buf (
    .clk(clk), .we(buf_we), .waddr(buf_waddr), .wdata(buf_wdata),
    .raddr(buf_raddr), .rdata(buf_rdata)
  );

  sd_blkseg_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_int_n), .ld(cnt_load), .ld_val(cnt_load_val),
    .dec(blk_dec), .cnt(blk_count)
  );

  sd_blkseg_ctl #(
    .AW(BUF_AW), .DW(DW), .LEN_W(LEN_W), .CNT_W(CNT_W), .BSZ_W(BSZ_W)
  ) u_ctl (
    .clk(clk), .rst_n(rst_int_n), .bs_field(cfg_blk_size[BSZ_W-1:0]),
    .cfg_rd(cfg_rd), .cfg_cnt_en(cfg_cnt_en), .abort(abort),
    .seg_start(seg_start), .seg_len(seg_len), .seg_busy(seg_busy),
    .seg_done(seg_done), .seg_used(seg_used), .cnt_val(blk_count),
    .blk_dec(blk_dec), .buf_we(buf_we), .buf_waddr(buf_waddr),
    .buf_wdata(buf_wdata), .buf_raddr(buf_raddr), .buf_rdata(buf_rdata),
    .mem_out_valid(mem_out_valid), .mem_out_ready(mem_out_ready),
    .mem_out_data(mem_out_data), .mem_in_valid(mem_in_valid),
    .mem_in_ready(mem_in_ready), .mem_in_data(mem_in_data),
    .card_in_valid(card_in_valid), .card_in_ready(card_in_ready),
    .card_in_data(card_in_data), .card_out_valid(card_out_valid),
    .card_out_ready(card_out_ready), .card_out_data(card_out_data)
  );
endmodule

// File: rtl/sd_blkseg_chk.sv
module sd_blkseg_chk #(
  parameter int DW    = 8,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             abort,
  input logic             cnt_load,
  input logic [CNT_W-1:0] blk_count,
  input logic             seg_busy,
  input logic             seg_done,
  input logic             mem_out_valid,
  input logic             mem_out_ready,
  input logic [DW-1:0]    mem_out_data,
  input logic             mem_in_ready,
  input logic             card_in_ready,
  input logic             card_out_valid,
  input logic             card_out_ready,
  input logic [DW-1:0]    card_out_data
);
  a_r9_one_stream: assert property (@(posedge clk) disable iff (!rst_n)
    $countones({card_in_ready, mem_out_valid, mem_in_ready, card_out_valid}) <= 1);

  a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !seg_busy |-> !(card_in_ready || mem_out_valid || mem_in_ready || card_out_valid));

  a_r7_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    seg_done |=> !seg_done);

  a_r8_abort_idle: assert property (@(posedge clk) disable iff (!rst_n)
    abort |=> (!seg_busy && !seg_done));

  a_r3_mem_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_out_valid && !mem_out_ready && !abort) |=> (mem_out_valid && $stable(mem_out_data)));

  a_r4_card_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (card_out_valid && !card_out_ready && !abort) |=> (card_out_valid && $stable(card_out_data)));

  a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_load |=> (blk_count == $past(blk_count) || blk_count == $past(blk_count) - CNT_W'(1)));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!seg_busy && !cnt_load) |=> $stable(blk_count));
endmodule

bind sd_blkseg sd_blkseg_chk #(.DW(DW), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/sd_blkseg_tb_top.sv
module sd_blkseg_tb_top;
  typedef struct packed {
    logic        rd;
    logic        cen;
    logic        ld;
    logic [15:0] ldv;
    logic [15:0] bs;
    logic [16:0] len;
    logic [16:0] used;
    logic [16:0] fetch;
    logic [16:0] flush;
    logic [15:0] cnt;
  } vec_t;

  // Block size field 0 or > 16 clamps to 16 (R1); fill carries over (R6).
  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{1'b1,1'b0,1'b0,16'd0,16'd8,17'd5,17'd5,17'd8,17'd0,16'd0},
    '{1'b1,1'b0,1'b0,16'd0,16'd8,17'd6,17'd6,17'd8,17'd0,16'd0},
    '{1'b1,1'b0,1'b0,16'd0,16'd8,17'd5,17'd5,17'd0,17'd0,16'd0},
    '{1'b1,1'b1,1'b1,16'd2,16'd8,17'd20,17'd16,17'd16,17'd0,16'd0},
    '{1'b1,1'b1,1'b0,16'd0,16'd8,17'd4,17'd0,17'd0,17'd0,16'd0},
    '{1'b1,1'b0,1'b0,16'd0,16'd8,17'd0,17'd0,17'd0,17'd0,16'd0},
    '{1'b0,1'b0,1'b0,16'd0,16'd8,17'd3,17'd3,17'd0,17'd0,16'd0},
    '{1'b0,1'b0,1'b0,16'd0,16'd8,17'd13,17'd13,17'd0,17'd16,16'd0},
    '{1'b0,1'b0,1'b0,16'd0,16'd8,17'd4,17'd4,17'd0,17'd0,16'd0},
    '{1'b0,1'b1,1'b1,16'd1,16'd8,17'd10,17'd4,17'd0,17'd8,16'd0},
    '{1'b0,1'b1,1'b1,16'd5,16'd0,17'd16,17'd16,17'd0,17'd16,16'd4},
    '{1'b0,1'b0,1'b0,16'd0,16'h00FF,17'd16,17'd16,17'd0,17'd16,16'd4},
    '{1'b1,1'b0,1'b0,16'd0,16'hF003,17'd7,17'd7,17'd9,17'd0,16'd4},
    '{1'b1,1'b0,1'b0,16'd0,16'hF003,17'd2,17'd2,17'd0,17'd0,16'd4},
    '{1'b1,1'b1,1'b1,16'd3,16'd16,17'd65536,17'd48,17'd48,17'd0,16'd0}
  };

  logic clk, rst_n;
  logic [15:0] cfg_blk_size, cnt_load_val, blk_count;
  logic cfg_rd, cfg_cnt_en, cnt_load, abort, seg_start, seg_busy, seg_done;
  logic [16:0] seg_len, seg_used;
  logic mem_out_valid, mem_out_ready, mem_in_valid, mem_in_ready;
  logic card_in_valid, card_in_ready, card_out_valid, card_out_ready;
  logic [7:0] mem_out_data, mem_in_data, card_in_data, card_out_data;

  int n_chk, n_fail, cyc;
  int card_rd_cnt, mem_out_cnt, mem_in_cnt, card_wr_cnt, mem_exp_idx, card_exp_idx;
  logic cur_rd;

  sd_blkseg #(.BUF_AW(4)) dut_i (.*);

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
  endtask

  // stream responders: drive at negedge, observe handshakes 1ns later
  initial begin
    cyc = 0;
    card_rd_cnt = 0; mem_out_cnt = 0; mem_in_cnt = 0; card_wr_cnt = 0;
    mem_exp_idx = 0; card_exp_idx = 0;
    card_in_valid = 1'b0; mem_out_ready = 1'b0; mem_in_valid = 1'b0; card_out_ready = 1'b0;
    card_in_data = 8'h00; mem_in_data = 8'h00;
    forever begin
      @(negedge clk);
      cyc++;
      card_in_valid  = (cyc % 3) != 0;
      mem_out_ready  = (cyc % 4) != 1;
      mem_in_valid   = (cyc % 5) != 2;
      card_out_ready = (cyc % 3) != 1;
      card_in_data   = 8'(card_rd_cnt) ^ 8'h5A;
      mem_in_data    = 8'(mem_in_cnt) ^ 8'hA5;
      #1;
      if (seg_busy) begin
        if (cur_rd) chk(!(mem_in_ready || card_out_valid), "R9 write stream active in read", 1, 0);
        else        chk(!(card_in_ready || mem_out_valid), "R9 read stream active in write", 1, 0);
      end
      if (card_in_valid && card_in_ready) card_rd_cnt++;
      if (mem_out_valid && mem_out_ready) begin
        chk(mem_out_data == (8'(mem_exp_idx) ^ 8'h5A), "R2 R3 mem_out byte",
            int'(mem_out_data), int'(8'(mem_exp_idx) ^ 8'h5A));
        mem_exp_idx++;
        mem_out_cnt++;
      end
      if (mem_in_valid && mem_in_ready) mem_in_cnt++;
      if (card_out_valid && card_out_ready) begin
        chk(card_out_data == (8'(card_exp_idx) ^ 8'hA5), "R4 card_out byte",
            int'(card_out_data), int'(8'(card_exp_idx) ^ 8'hA5));
        card_exp_idx++;
        card_wr_cnt++;
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  task automatic run_seg(input logic [16:0] len, output int used, output bit saw_done);
    @(negedge clk);
    seg_start = 1'b1;
    seg_len = len;
    @(negedge clk);
    seg_start = 1'b0;
    saw_done = 1'b0;
    used = 0;
    for (int k = 0; k < 5000; k++) begin
      @(negedge clk);
      #2;
      if (seg_done) begin
        saw_done = 1'b1;
        used = int'(seg_used);
        break;
      end
    end
  endtask

  task automatic run_vec(input vec_t v, input int id);
    int f0, w0, used;
    bit sd;
    @(negedge clk);
    cfg_rd = v.rd;
    cur_rd = v.rd;
    cfg_cnt_en = v.cen;
    cfg_blk_size = v.bs;
    if (v.ld) begin
      cnt_load = 1'b1;
      cnt_load_val = v.ldv;
      @(negedge clk);
      cnt_load = 1'b0;
    end
    f0 = card_rd_cnt;
    w0 = card_wr_cnt;
    run_seg(v.len, used, sd);
    chk(sd, $sformatf("vec %0d R7 done pulse", id), int'(sd), 1);
    chk(used == int'(v.used), $sformatf("vec %0d R3 R5 R7 used", id), used, int'(v.used));
    chk(card_rd_cnt - f0 == int'(v.fetch), $sformatf("vec %0d R1 R2 R6 fetched", id),
        card_rd_cnt - f0, int'(v.fetch));
    chk(card_wr_cnt - w0 == int'(v.flush), $sformatf("vec %0d R1 R4 R6 flushed", id),
        card_wr_cnt - w0, int'(v.flush));
    chk(blk_count == v.cnt, $sformatf("vec %0d R5 R10 count", id), int'(blk_count), int'(v.cnt));
  endtask

  initial begin
    int used, f0, w0;
    bit sd;
    n_chk = 0; n_fail = 0;
    rst_n = 1'b0;
    cfg_blk_size = 16'd8; cfg_rd = 1'b1; cfg_cnt_en = 1'b0; cur_rd = 1'b1;
    cnt_load = 1'b0; cnt_load_val = 16'd0; abort = 1'b0;
    seg_start = 1'b0; seg_len = 17'd0;
    repeat (3) @(negedge clk);
    #2;
    chk(!seg_busy && !seg_done, "RST R8 busy/done after reset", int'(seg_busy), 0);
    chk(blk_count == 16'd0, "RST R10 count after reset", int'(blk_count), 0);
    chk(!(card_in_ready || mem_out_valid || mem_in_ready || card_out_valid),
        "RST R9 streams quiet after reset", 1, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R8: abort while idle discards a partial read block
    @(negedge clk);
    cfg_rd = 1'b1; cur_rd = 1'b1; cfg_cnt_en = 1'b0; cfg_blk_size = 16'd8;
    run_seg(17'd3, used, sd);
    chk(used == 3, "R8 pre-abort read used", used, 3);
    @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    mem_exp_idx = card_rd_cnt;
    f0 = card_rd_cnt;
    run_seg(17'd8, used, sd);
    chk(card_rd_cnt - f0 == 8, "R8 read refetch after abort", card_rd_cnt - f0, 8);
    chk(used == 8, "R8 read used after abort", used, 8);

    // R8: abort in the middle of a long write segment
    @(negedge clk);
    cfg_rd = 1'b0; cur_rd = 1'b0;
    seg_start = 1'b1;
    seg_len = 17'd100;
    @(negedge clk);
    seg_start = 1'b0;
    repeat (15) @(negedge clk);
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    #2;
    chk(!seg_busy && !seg_done, "R8 idle after abort", int'(seg_busy), 0);
    card_exp_idx = mem_in_cnt;
    w0 = card_wr_cnt;
    run_seg(17'd8, used, sd);
    chk(card_wr_cnt - w0 == 8, "R8 write new block after abort", card_wr_cnt - w0, 8);
    chk(used == 8, "R8 write used after abort", used, 8);

    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule